// File: doc/BRIEF.md
# Configurable Set/Reset Storage Cell

This block is a row of single-bit storage cells whose behaviour is fixed by parameters at build time. Each cell is either an edge-triggered flip-flop or a level-sensitive latch that is open while the clock is high. A clock-enable gates data capture. Two shared control lines, `sr` and `rev`, can force every bit to all ones or all zeros. A parameter picks which of the two lines asks for ones and which asks for zeros.

A mode parameter selects one of seven set/reset behaviours. The mode decides whether forcing to ones, forcing to zeros, or both are allowed, and whether they act on the clock or at once. A global load input puts every bit back to its own power-up value at once and overrides everything else. A chip instantiates the cell wherever a register must match a fixed reset/preset convention.

Top module: `cfg_store_cell`

## Requirements
- R1: Mode codes are NONE=0, SYNC_SET=1, SYNC_RESET=2, SYNC_BOTH=3, ASYNC_PRESET=4, ASYNC_CLEAR=5, ASYNC_BOTH=6. In NONE, `sr` and `rev` have no effect on `q`.
- R2: In flip-flop mode with no force active, each rising clock edge with `ce` high loads `d` into `q`. With `ce` low, `q` holds its value.
- R3: In SYNC_SET and SYNC_BOTH, a set request present at a rising edge drives `q` to all ones, whatever the level of `ce`.
- R4: In SYNC_RESET and SYNC_BOTH, a reset request present at a rising edge drives `q` to all zeros, whatever the level of `ce`.
- R5: In SYNC_BOTH, when set and reset are requested together, `q` goes to all zeros.
- R6: In the asynchronous modes, a preset request drives `q` to all ones at once and a clear request drives it to all zeros at once, with no clock needed. Clear wins when both are requested. When clear is released while preset is still held, `q` becomes all ones. After all requests are released, the forced value is held until the next capture.
- R7: While `init_load` is high, `q` equals `INIT_VAL` at once, and this overrides every other input. After `init_load` falls, that value is held until something else changes it.
- R8: When `SR_FORCES_ONE`=1, `sr` requests ones and `rev` requests zeros. When it is 0, the roles swap. A request of a kind the mode does not provide is ignored.
- R9: In latch mode, `q` follows `d` while `clk` is high and `ce` is high. `q` holds while `clk` is low. Synchronous forces act while `clk` is high. Asynchronous forces and `init_load` act at any clock level.
- R10: All bits share `ce`, `sr`, `rev` and `init_load`. Each bit captures its own `d` bit and loads its own `INIT_VAL` bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock; also the latch gate, open while high |
| init_load | input | 1 | Global load of the power-up value, active high, asynchronous |
| d | input | WIDTH | Data to store |
| ce | input | 1 | Clock-enable for data capture |
| sr | input | 1 | Shared set/reset line; its polarity follows SR_FORCES_ONE |
| rev | input | 1 | Reverse line; it forces the value opposite to `sr` |
| q | output | WIDTH | Stored value |

## Verification
The bench builds nine copies of the cell: all seven modes as flip-flops, plus two latch variants, with both polarities of the control lines. A behavioural model checks all nine after every input change and after every rising edge. One targeted case raises both control lines together, where a swapped priority would leave ones instead of zeros. Another releases clear while preset is still held; a design that misses this would keep zeros. A third holds `ce` low while a synchronous force is active; a design that gates forces by the enable would hold the old data. A further case asserts `init_load` during an active force, where a wrong priority would show the forced value instead of the per-bit power-up pattern. Changing `d` while the latch gate is closed exposes a latch that stays transparent.

// File: rtl/cfg_store_pkg.sv
`timescale 1ns/1ps
package cfg_store_pkg;

  typedef enum logic [2:0] {
    SRM_NONE  = 3'd0,
    SRM_SSET  = 3'd1,
    SRM_SRST  = 3'd2,
    SRM_SSR   = 3'd3,
    SRM_APRE  = 3'd4,
    SRM_ACLR  = 3'd5,
    SRM_APC   = 3'd6
  } srm_e;

  function automatic bit srm_has_set(srm_e m);
    return (m == SRM_SSET) || (m == SRM_SSR) || (m == SRM_APRE) || (m == SRM_APC);
  endfunction

  function automatic bit srm_has_clr(srm_e m);
    return (m == SRM_SRST) || (m == SRM_SSR) || (m == SRM_ACLR) || (m == SRM_APC);
  endfunction

  function automatic bit srm_is_async(srm_e m);
    return (m == SRM_APRE) || (m == SRM_ACLR) || (m == SRM_APC);
  endfunction

endpackage

// File: rtl/cfg_store_srdec.sv
`timescale 1ns/1ps
// Turns the shared control lines into resolved force requests for one mode.
module cfg_store_srdec
  import cfg_store_pkg::*;
#(
  parameter srm_e MODE          = SRM_NONE,
  parameter bit   SR_FORCES_ONE = 1'b1
) (
  input  logic init_load,
  input  logic sr,
  input  logic rev,
  output logic sync_set,
  output logic sync_clr,
  output logic async_pre,
  output logic async_clr
);
  localparam bit HAS_SET  = srm_has_set(MODE);
  localparam bit HAS_CLR  = srm_has_clr(MODE);
  localparam bit IS_ASYNC = srm_is_async(MODE);

  logic set_req, clr_req, want_set, want_clr, open_n;

  assign set_req  = SR_FORCES_ONE ? sr  : rev;
  assign clr_req  = SR_FORCES_ONE ? rev : sr;
  // zeros beat ones in every mode
  assign want_clr = HAS_CLR && clr_req;
  assign want_set = HAS_SET && set_req && !want_clr;
  // global load masks forces so its release re-triggers a held force
  assign open_n   = !init_load;

  generate
    if (IS_ASYNC) begin : g_async
      assign async_clr = want_clr && open_n;
      assign async_pre = want_set && open_n;
      assign sync_clr  = 1'b0;
      assign sync_set  = 1'b0;
    end else begin : g_sync
      assign async_clr = 1'b0;
      assign async_pre = 1'b0;
      assign sync_clr  = want_clr && open_n;
      assign sync_set  = want_set && open_n;
    end
  endgenerate
endmodule

// File: rtl/cfg_store_ff.sv
`timescale 1ns/1ps
// Edge-triggered bit with asynchronous load, clear and preset.
module cfg_store_ff #(
  parameter bit INIT_BIT = 1'b0
) (
  input  logic clk,
  input  logic init_load,
  input  logic a_clr,
  input  logic a_pre,
  input  logic s_clr,
  input  logic s_set,
  input  logic ce,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or posedge init_load or posedge a_clr or posedge a_pre) begin
    if (init_load)  q <= INIT_BIT;
    else if (a_clr) q <= 1'b0;
    else if (a_pre) q <= 1'b1;
    else if (s_clr) q <= 1'b0;
    else if (s_set) q <= 1'b1;
    else if (ce)    q <= d;
  end
endmodule

// File: rtl/cfg_store_latch.sv
`timescale 1ns/1ps
// Level-sensitive bit, open while gate is high.
module cfg_store_latch #(
  parameter bit INIT_BIT = 1'b0
) (
  input  logic gate,
  input  logic init_load,
  input  logic a_clr,
  input  logic a_pre,
  input  logic s_clr,
  input  logic s_set,
  input  logic ce,
  input  logic d,
  output logic q
);
  always_latch begin
    if (init_load)  q = INIT_BIT;
    else if (a_clr) q = 1'b0;
    else if (a_pre) q = 1'b1;
    else if (gate) begin
      if (s_clr)      q = 1'b0;
      else if (s_set) q = 1'b1;
      else if (ce)    q = d;
    end
  end
endmodule

// File: rtl/cfg_store_cell.sv
`timescale 1ns/1ps
module cfg_store_cell
  import cfg_store_pkg::*;
#(
  parameter int               WIDTH         = 8,
  parameter srm_e             MODE          = SRM_NONE,
  parameter bit               IS_LATCH      = 1'b0,
  parameter bit               SR_FORCES_ONE = 1'b1,
  parameter logic [WIDTH-1:0] INIT_VAL      = '0
) (
  input  logic             clk,
  input  logic             init_load,
  input  logic [WIDTH-1:0] d,
  input  logic             ce,
  input  logic             sr,
  input  logic             rev,
  output logic [WIDTH-1:0] q
);
  logic sync_set, sync_clr, async_pre, async_clr;

  cfg_store_srdec #(
    .MODE          (MODE),
    .SR_FORCES_ONE (SR_FORCES_ONE)
  ) i_dec (
    .init_load (init_load),
    .sr        (sr),
    .rev       (rev),
    .sync_set  (sync_set),
    .sync_clr  (sync_clr),
    .async_pre (async_pre),
    .async_clr (async_clr)
  );

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    if (IS_LATCH) begin : g_lat
      cfg_store_latch #(.INIT_BIT(INIT_VAL[b])) i_cell (
        .gate (clk), .init_load (init_load),
        .a_clr (async_clr), .a_pre (async_pre),
        .s_clr (sync_clr), .s_set (sync_set),
        .ce (ce), .d (d[b]), .q (q[b])
      );
    end else begin : g_reg
      cfg_store_ff #(.INIT_BIT(INIT_VAL[b])) i_cell (
        .clk (clk), .init_load (init_load),
        .a_clr (async_clr), .a_pre (async_pre),
        .s_clr (sync_clr), .s_set (sync_set),
        .ce (ce), .d (d[b]), .q (q[b])
      );
    end
  end
endmodule

// File: rtl/cfg_store_cell_chk.sv
`timescale 1ns/1ps
module cfg_store_cell_chk
  import cfg_store_pkg::*;
#(
  parameter int               WIDTH    = 8,
  parameter srm_e             MODE     = SRM_NONE,
  parameter bit               IS_LATCH = 1'b0,
  parameter logic [WIDTH-1:0] INIT_VAL = '0
) (
  input logic             clk,
  input logic             init_load,
  input logic [WIDTH-1:0] d,
  input logic             ce,
  input logic             sr,
  input logic             rev,
  input logic [WIDTH-1:0] q,
  input logic             sync_set,
  input logic             sync_clr,
  input logic             async_pre,
  input logic             async_clr
);
  logic quiet;
  assign quiet = !sync_set && !sync_clr && !async_pre && !async_clr;

  assert_capture_R2: assert property (@(posedge clk) disable iff (init_load)
    (!IS_LATCH && ce && quiet) |=> (async_pre || async_clr || q == $past(d)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (init_load)
    (!IS_LATCH && !ce && quiet) |=> (async_pre || async_clr || $stable(q)));

  assert_sync_set_R3: assert property (@(posedge clk) disable iff (init_load)
    (!IS_LATCH && sync_set) |=> (async_pre || async_clr || q == '1));

  assert_sync_reset_R4: assert property (@(posedge clk) disable iff (init_load)
    (!IS_LATCH && sync_clr) |=> (async_pre || async_clr || q == '0));

  assert_sync_priority_R5: assert property (@(posedge clk) disable iff (init_load)
    (!IS_LATCH && MODE == SRM_SSR && sr && rev) |=> (async_pre || async_clr || q == '0));

  assert_async_clear_R6: assert property (@(posedge clk) disable iff (init_load)
    async_clr |-> q == '0);

  assert_async_preset_R6: assert property (@(posedge clk) disable iff (init_load)
    async_pre |-> q == '1);

  assert_async_priority_R6: assert property (@(posedge clk) disable iff (init_load)
    (MODE == SRM_APC && sr && rev) |-> q == '0);

  assert_init_load_R7: assert property (@(posedge clk)
    init_load |-> q == INIT_VAL);
endmodule

bind cfg_store_cell cfg_store_cell_chk #(
  .WIDTH (WIDTH), .MODE (MODE), .IS_LATCH (IS_LATCH), .INIT_VAL (INIT_VAL)
) i_chk (
  .clk (clk), .init_load (init_load), .d (d), .ce (ce), .sr (sr), .rev (rev),
  .q (q), .sync_set (sync_set), .sync_clr (sync_clr),
  .async_pre (async_pre), .async_clr (async_clr)
);

// File: tb/test_cfg_store_cell.sv
`timescale 1ns/1ps
module test_cfg_store_cell;
  localparam int N = 9;
  localparam int W = 4;
  // mode code, latch flag, polarity, power-up value per copy
  localparam int MODE_T [N] = '{0, 1, 2, 3, 4, 5, 6, 3, 6};
  localparam int LAT_T  [N] = '{0, 0, 0, 0, 0, 0, 0, 1, 1};
  localparam int POL_T  [N] = '{1, 1, 1, 0, 1, 0, 1, 1, 0};
  localparam logic [W-1:0] INIT_T [N] =
    '{4'hA, 4'h5, 4'h0, 4'hF, 4'h3, 4'h6, 4'h9, 4'hC, 4'h1};

  logic         clk = 1'b0;
  logic         init_load = 1'b0;
  logic [W-1:0] d = '0;
  logic         ce = 1'b0, sr = 1'b0, rev = 1'b0;
  logic [W-1:0] q_all [N];
  logic [W-1:0] expv  [N];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  for (genvar g = 0; g < N; g++) begin : g_dut
    cfg_store_cell #(
      .WIDTH (W),
      .MODE (cfg_store_pkg::srm_e'(MODE_T[g])),
      .IS_LATCH (LAT_T[g] != 0),
      .SR_FORCES_ONE (POL_T[g] != 0),
      .INIT_VAL (INIT_T[g])
    ) i_cfg_store_cell (
      .clk (clk), .init_load (init_load), .d (d), .ce (ce),
      .sr (sr), .rev (rev), .q (q_all[g])
    );
  end

  // behavioural reference: apply whatever the inputs call for now
  task automatic model_update(input bit at_edge, input bit gate_high);
    for (int g = 0; g < N; g++) begin
      int m;
      bit setq, clrq, hs, hc, as, wc, ws, lat;
      m    = MODE_T[g];
      lat  = LAT_T[g] != 0;
      setq = (POL_T[g] != 0) ? sr  : rev;
      clrq = (POL_T[g] != 0) ? rev : sr;
      hs   = (m == 1) || (m == 3) || (m == 4) || (m == 6);
      hc   = (m == 2) || (m == 3) || (m == 5) || (m == 6);
      as   = m >= 4;
      wc   = hc && clrq;
      ws   = hs && setq && !wc;
      if (init_load)     expv[g] = INIT_T[g];
      else if (as && wc) expv[g] = '0;
      else if (as && ws) expv[g] = '1;
      else if ((lat && gate_high) || (!lat && at_edge)) begin
        if (wc)      expv[g] = '0;
        else if (ws) expv[g] = '1;
        else if (ce) expv[g] = d;
      end
    end
  endtask

  task automatic compare(input string req);
    for (int g = 0; g < N; g++) begin
      checks++;
      if (q_all[g] !== expv[g]) begin
        fails++;
        $display("FAIL %s copy %0d mode %0d t=%0t: actual=%b expected=%b",
                 req, g, MODE_T[g], $time, q_all[g], expv[g]);
      end
    end
  endtask

  task automatic step(input logic [W-1:0] nd, input bit nce, input bit nsr,
                      input bit nrev, input bit ninit, input string req);
    @(negedge clk);
    #1;
    d = nd; ce = nce; sr = nsr; rev = nrev; init_load = ninit;
    #1;
    model_update(1'b0, 1'b0);
    compare(req);
    @(posedge clk);
    #1;
    model_update(1'b1, 1'b1);
    compare(req);
  endtask

  initial begin
    for (int g = 0; g < N; g++) expv[g] = 'x;
    #1 init_load = 1'b1;
    step(4'h5, 1, 0, 0, 1, "R7");   // reset state: every copy at its power-up value
    step(4'h3, 1, 0, 0, 0, "R2");   // capture with enable
    step(4'hC, 0, 0, 0, 0, "R2");   // enable low holds
    step(4'h0, 0, 1, 0, 0, "R3");   // sr alone: sync forces ignore enable, R1 none unaffected
    step(4'h0, 0, 1, 1, 0, "R5");   // both lines: zeros win
    step(4'h0, 0, 0, 1, 0, "R4");   // rev alone, polarity R8
    step(4'hF, 1, 0, 0, 0, "R9");   // latch open with enable
    step(4'h0, 1, 1, 1, 0, "R6");   // async both held
    step(4'h0, 1, 1, 0, 0, "R6");   // release the zero request only
    step(4'h5, 0, 0, 0, 0, "R6");   // all released, value kept
    step(4'h5, 0, 1, 0, 1, "R7");   // load beats an active force
    step(4'h5, 0, 0, 0, 0, "R7");   // load value kept after release
    step(4'h6, 1, 0, 0, 0, "R10");  // per-bit capture
    step(4'h9, 1, 0, 1, 0, "R8");   // swapped polarity copies
    for (int i = 0; i < 80; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      step(4'($urandom), r[0], r[1] & r[2], r[3] & r[4], r[7:5] == 3'b111 && r[0], "R1");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule